// File: doc/BRIEF.md
# Queued SPI Transfer Sequencer

This block sits in front of an SPI bit engine and runs a list of transfers from a small on-chip queue. Every queue slot has three parts: a transmit word, a receive word and a command word. The command word gives the chip-select pattern, the transfer length, a pause measured in clock cycles, and a flag that keeps the chip select held into the next slot. The host fills the slots through a plain word port. It then gives a first and a last slot index and pulses `go`. The sequencer handles the slots from first to last. For each one it hands the engine a command, waits for the engine's response, and writes the received word into the same slot. After the run the host reads the results as ordinary memory.

The index counts up modulo the queue depth, so a last index below the first index wraps through slot 0. If `wrap_en` is high at `go`, the sequencer returns to the first slot after the last one and keeps going. It stops only when the host pulses `halt`, and it stops at the next slot boundary. Without wrap-around the run ends after the last slot and raises `done`.

The engine side uses two valid/ready streams. On the command stream the sequencer holds `cmd_valid` and keeps the payload unchanged until the engine asserts `cmd_ready`. On the response stream `rsp_ready` is high only while one accepted command is waiting for its answer, so the engine may stall a response for as long as it needs to. Only one transfer is ever in flight.

Top module: `spi_queue_seq`

## Requirements
- R1: While reset is applied and just after it, `busy`, `done`, `cmd_valid` and `rsp_ready` are 0, `cs_n` is all ones and `cur_ptr` is 0.
- R2: A host write updates one field of slot `host_addr`. The field code is 0 for transmit, 1 for receive and 2 for command. `host_rdata` returns the addressed field one clock after the address is presented. The command word bits are: [16] hold select, [15:12] select pattern, [11:8] length minus one, [7:0] pause cycles.
- R3: A `go` pulse while idle latches the first and last index and raises `busy`. Slots are offered in order with the index stepping by one modulo 16. Each command carries the slot's transmit word, length field and select pattern, and `cur_ptr` shows the slot index. A `go` pulse while busy is ignored.
- R4: `cmd_valid` stays high with a stable payload until `cmd_ready`. `rsp_ready` is never high together with `cmd_valid`.
- R5: The `rsp_data` accepted for a slot is written into that slot's receive field.
- R6: While a command is offered, `cs_n` equals the inverted select pattern. At the response handshake `cs_n` returns to all ones, unless the slot's hold flag is set; in that case it keeps its value until the next slot drives its own pattern.
- R7: With a pause of d cycles, the next command is first offered d+2 cycles after the cycle of the response handshake.
- R8: Without wrap-around, after the last slot's pause `busy` falls, `done` rises and `cs_n` is all ones. `done` stays high until the next `go`.
- R9: With wrap-around, the slot after the last index is the first index again, and the run goes on without host action.
- R10: A `halt` pulse lets the current slot finish, including its pause, and then stops the run with `done` left at 0.
- R11: If the last index is below the first index, the run passes from slot 15 to slot 0 and covers (last-first) mod 16 + 1 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host write strobe |
| host_fld | input | 2 | Field code: 0 transmit, 1 receive, 2 command |
| host_addr | input | 4 | Slot index for host access |
| host_wdata | input | 17 | Host write data |
| host_rdata | output | 17 | Registered host read data |
| go | input | 1 | Start pulse |
| halt | input | 1 | Stop at next slot boundary |
| wrap_en | input | 1 | Endless wrap-around, latched at go |
| start_ptr | input | 4 | First slot index |
| end_ptr | input | 4 | Last slot index |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed normally |
| cur_ptr | output | 4 | Slot currently being handled |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| cmd_data | output | 16 | Word to transmit |
| cmd_len | output | 4 | Transfer length minus one |
| cmd_cs | output | 4 | Select pattern for this transfer |
| rsp_valid | input | 1 | Response stream valid |
| rsp_ready | output | 1 | Response stream ready |
| rsp_data | input | 16 | Received word |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench drives random slot contents and random engine stalls on both streams. It also runs a few directed cases: a single-slot run, a run that wraps from slot 15 to slot 0, a long pause on a slot with the hold flag set, a second `go` during a run, and a halt during an endless run. A design that counted the pause wrongly would shift the next command's first cycle away from d+2. A design that ignored the hold flag would show all-ones `cs_n` on the cycle after the response. Wrong index arithmetic shows up as the wrong slot being offered or the wrong number of transfers. A halt that acted at once, rather than at the boundary, would cut the transfer count short or raise `done`.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ISSUE,
    ST_WAIT,
    ST_DELAY
  } seq_state_e;

  localparam logic [1:0] FLD_TX  = 2'd0;
  localparam logic [1:0] FLD_RX  = 2'd1;
  localparam logic [1:0] FLD_CMD = 2'd2;

endpackage

// File: rtl/qspi_queue_ram.sv
module qspi_queue_ram
  import qspi_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int CMD_W  = 17,
  parameter int HOST_W = 17,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic [1:0]        h_fld,
  input  logic [PTR_W-1:0]  h_addr,
  input  logic [HOST_W-1:0] h_wdata,
  output logic [HOST_W-1:0] h_rdata,
  input  logic [PTR_W-1:0]  seq_addr,
  output logic [DATA_W-1:0] seq_tx,
  output logic [CMD_W-1:0]  seq_cmd,
  input  logic              rx_we,
  input  logic [PTR_W-1:0]  rx_addr,
  input  logic [DATA_W-1:0] rx_data
);

  logic [DATA_W-1:0] tx_q  [DEPTH];
  logic [DATA_W-1:0] rx_q  [DEPTH];
  logic [CMD_W-1:0]  cmd_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    assign hit = (h_addr == PTR_W'(i)) && h_we;

    always_ff @(posedge clk) begin
      if (hit && h_fld == FLD_TX)  tx_q[i]  <= h_wdata[DATA_W-1:0];
      if (hit && h_fld == FLD_CMD) cmd_q[i] <= h_wdata[CMD_W-1:0];
      if (rx_we && rx_addr == PTR_W'(i)) rx_q[i] <= rx_data;
      else if (hit && h_fld == FLD_RX)   rx_q[i] <= h_wdata[DATA_W-1:0];
    end
  end

  assign seq_tx  = tx_q[seq_addr];
  assign seq_cmd = cmd_q[seq_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rdata <= '0;
    end else begin
      unique case (h_fld)
        FLD_TX:  h_rdata <= HOST_W'(tx_q[h_addr]);
        FLD_RX:  h_rdata <= HOST_W'(rx_q[h_addr]);
        FLD_CMD: h_rdata <= HOST_W'(cmd_q[h_addr]);
        default: h_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/qspi_dly_timer.sv
module qspi_dly_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             last
);

  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last = (cnt == DLY_W'(1));

endmodule

// File: rtl/qspi_seq_fsm.sv
module qspi_seq_fsm
  import qspi_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int CS_W   = 4,
  parameter int LEN_W  = 4,
  parameter int DLY_W  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CMD_W = CS_W + LEN_W + DLY_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              halt,
  input  logic              wrap_en,
  input  logic [PTR_W-1:0]  start_ptr,
  input  logic [PTR_W-1:0]  end_ptr,
  input  logic [DATA_W-1:0] ent_tx,
  input  logic [CMD_W-1:0]  ent_cmd,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_data,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [CS_W-1:0]   cmd_cs,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rx_we,
  output logic [PTR_W-1:0]  rx_addr,
  output logic [DATA_W-1:0] rx_data,
  output logic              tmr_load,
  output logic [DLY_W-1:0]  tmr_val,
  input  logic              tmr_last,
  output logic [CS_W-1:0]   cs_n,
  output logic              busy,
  output logic              done
);

  localparam int CS_LSB = DLY_W + LEN_W;

  seq_state_e        st;
  logic [PTR_W-1:0]  ptr, first_q, last_q, ptr_inc;
  logic              wrap_q, halt_pend;
  logic [DATA_W-1:0] lat_tx;
  logic [LEN_W-1:0]  lat_len;
  logic [CS_W-1:0]   lat_cs;
  logic [DLY_W-1:0]  lat_dly;
  logic              lat_hold;
  logic [CS_W-1:0]   cs_q;
  logic              rsp_hs, step, stop_req, at_last;

  assign ptr_inc  = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  assign rsp_hs   = (st == ST_WAIT) && rsp_valid;
  assign step     = (rsp_hs && lat_dly == '0) || (st == ST_DELAY && tmr_last);
  assign stop_req = halt_pend || halt;
  assign at_last  = (ptr == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ptr       <= '0;
      first_q   <= '0;
      last_q    <= '0;
      wrap_q    <= 1'b0;
      halt_pend <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      cs_q      <= '1;
      lat_tx    <= '0;
      lat_len   <= '0;
      lat_cs    <= '0;
      lat_dly   <= '0;
      lat_hold  <= 1'b0;
    end else begin
      if (halt && st != ST_IDLE) halt_pend <= 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (go) begin
            first_q   <= start_ptr;
            last_q    <= end_ptr;
            wrap_q    <= wrap_en;
            ptr       <= start_ptr;
            busy      <= 1'b1;
            done      <= 1'b0;
            halt_pend <= 1'b0;
            st        <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          lat_tx   <= ent_tx;
          lat_dly  <= ent_cmd[DLY_W-1:0];
          lat_len  <= ent_cmd[DLY_W +: LEN_W];
          lat_cs   <= ent_cmd[CS_LSB +: CS_W];
          lat_hold <= ent_cmd[CMD_W-1];
          cs_q     <= ~ent_cmd[CS_LSB +: CS_W];
          st       <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (cmd_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (!lat_hold) cs_q <= '1;
            if (lat_dly != '0) st <= ST_DELAY;
          end
        end
        ST_DELAY: ;
        default: st <= ST_IDLE;
      endcase
      if (step) begin
        if (stop_req || (at_last && !wrap_q)) begin
          st        <= ST_IDLE;
          busy      <= 1'b0;
          done      <= !stop_req;
          cs_q      <= '1;
          halt_pend <= 1'b0;
        end else begin
          st  <= ST_LOAD;
          ptr <= at_last ? first_q : ptr_inc;
        end
      end
    end
  end

  assign rd_ptr    = ptr;
  assign cmd_valid = (st == ST_ISSUE);
  assign cmd_data  = lat_tx;
  assign cmd_len   = lat_len;
  assign cmd_cs    = lat_cs;
  assign rsp_ready = (st == ST_WAIT);
  assign rx_we     = rsp_hs;
  assign rx_addr   = ptr;
  assign rx_data   = rsp_data;
  assign tmr_load  = rsp_hs && (lat_dly != '0);
  assign tmr_val   = lat_dly;
  assign cs_n      = cs_q;

endmodule

// File: rtl/spi_queue_seq.sv
module spi_queue_seq
  import qspi_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int CS_W   = 4,
  parameter int LEN_W  = 4,
  parameter int DLY_W  = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CMD_W  = CS_W + LEN_W + DLY_W + 1,
  localparam int HOST_W = (DATA_W > CMD_W) ? DATA_W : CMD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_fld,
  input  logic [PTR_W-1:0]  host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              go,
  input  logic              halt,
  input  logic              wrap_en,
  input  logic [PTR_W-1:0]  start_ptr,
  input  logic [PTR_W-1:0]  end_ptr,
  output logic              busy,
  output logic              done,
  output logic [PTR_W-1:0]  cur_ptr,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_data,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [CS_W-1:0]   cmd_cs,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [CS_W-1:0]   cs_n
);

  logic [PTR_W-1:0]  rd_ptr, rx_addr;
  logic [DATA_W-1:0] ent_tx, rx_data;
  logic [CMD_W-1:0]  ent_cmd;
  logic              rx_we, tmr_load, tmr_last;
  logic [DLY_W-1:0]  tmr_val;

  qspi_queue_ram #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .CMD_W(CMD_W), .HOST_W(HOST_W)
  ) ram_i (
    .clk(clk), .rst_n(rst_n),
    .h_we(host_we), .h_fld(host_fld), .h_addr(host_addr),
    .h_wdata(host_wdata), .h_rdata(host_rdata),
    .seq_addr(rd_ptr), .seq_tx(ent_tx), .seq_cmd(ent_cmd),
    .rx_we(rx_we), .rx_addr(rx_addr), .rx_data(rx_data)
  );

  qspi_dly_timer #(.DLY_W(DLY_W)) tmr_i (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  qspi_seq_fsm #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .CS_W(CS_W), .LEN_W(LEN_W), .DLY_W(DLY_W)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .go(go), .halt(halt), .wrap_en(wrap_en),
    .start_ptr(start_ptr), .end_ptr(end_ptr),
    .ent_tx(ent_tx), .ent_cmd(ent_cmd), .rd_ptr(rd_ptr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_len(cmd_len), .cmd_cs(cmd_cs),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rx_we(rx_we), .rx_addr(rx_addr), .rx_data(rx_data),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_last(tmr_last),
    .cs_n(cs_n), .busy(busy), .done(done)
  );

  assign cur_ptr = rd_ptr;

endmodule

// File: rtl/qspi_seq_chk.sv
module qspi_seq_chk #(
  parameter int DATA_W = 16,
  parameter int CS_W   = 4,
  parameter int LEN_W  = 4,
  parameter int PTR_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [CS_W-1:0]   cs_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [DATA_W-1:0] cmd_data,
  input logic [LEN_W-1:0]  cmd_len,
  input logic [CS_W-1:0]   cmd_cs,
  input logic              rsp_ready,
  input logic [PTR_W-1:0]  cur_ptr
);

  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data) && $stable(cmd_len) && $stable(cmd_cs));

  // R4
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rsp_ready));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !cmd_valid && !rsp_ready);

  // R6
  cs_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n == '1);

  // R6
  cs_during_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cs_n == ~cmd_cs);

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> $stable(cur_ptr));

endmodule

bind spi_queue_seq qspi_seq_chk #(
  .DATA_W(DATA_W), .CS_W(CS_W), .LEN_W(LEN_W), .PTR_W(PTR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cs_n(cs_n),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
  .cmd_len(cmd_len), .cmd_cs(cmd_cs), .rsp_ready(rsp_ready), .cur_ptr(cur_ptr)
);

// File: tb/spi_queue_seq_tb.sv
`timescale 1ns/1ps
module spi_queue_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [1:0]  host_fld;
  logic [3:0]  host_addr;
  logic [16:0] host_wdata;
  logic [16:0] host_rdata;
  logic        go, halt, wrap_en;
  logic [3:0]  start_ptr, end_ptr;
  logic        busy, done;
  logic [3:0]  cur_ptr;
  logic        cmd_valid, cmd_ready;
  logic [15:0] cmd_data;
  logic [3:0]  cmd_len, cmd_cs;
  logic        rsp_valid, rsp_ready;
  logic [15:0] rsp_data;
  logic [3:0]  cs_n;

  always #5 clk = ~clk;

  spi_queue_seq dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_fld(host_fld),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .go(go), .halt(halt), .wrap_en(wrap_en), .start_ptr(start_ptr), .end_ptr(end_ptr),
    .busy(busy), .done(done), .cur_ptr(cur_ptr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_len(cmd_len), .cmd_cs(cmd_cs),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .cs_n(cs_n)
  );

  int checks = 0;
  int failures = 0;

  logic [15:0] m_tx  [16];
  logic [16:0] m_cmd [16];
  logic [15:0] exp_rx[16];
  int  run_start, run_end, run_len, hs_cnt, halt_at;
  bit  run_wrap;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] f_cs(input logic [16:0] c);  return c[15:12]; endfunction
  function automatic logic [3:0] f_len(input logic [16:0] c); return c[11:8];  endfunction
  function automatic int f_dly(input logic [16:0] c);         return int'(c[7:0]); endfunction
  function automatic bit f_hold(input logic [16:0] c);        return c[16];    endfunction
  function automatic int exp_index(input int k); return (run_start + (k % run_len)) % 16; endfunction
  function automatic logic [15:0] resp_of(input int idx);
    logic [16:0] mask;
    mask = (17'h1 << (int'(f_len(m_cmd[idx])) + 1)) - 17'h1;
    return (m_tx[idx] ^ 16'h5A3C) & mask[15:0];
  endfunction

  // Engine model and monitor
  initial begin
    int cyc, last_rsp_cyc, last_dly, cur_idx, wait_n;
    bit prev_cv, rsp_seen, have, hs_c, hs_r, stop;
    logic [3:0] exp_cs_after;
    cmd_ready = 0; rsp_valid = 0; rsp_data = 0; halt = 0;
    cyc = 0; last_rsp_cyc = 0; last_dly = 0; cur_idx = 0; wait_n = 0;
    prev_cv = 0; rsp_seen = 0; have = 0; exp_cs_after = '1;
    forever begin
      @(negedge clk);
      cyc++;
      hs_c = cmd_valid && cmd_ready;
      hs_r = rsp_valid && rsp_ready;
      if (rst_n) begin
        if (cmd_valid && !prev_cv && hs_cnt > 0)
          chk(cyc - last_rsp_cyc == last_dly + 2, "R7 gap", cyc - last_rsp_cyc, last_dly + 2);
        if (rsp_seen && cyc == last_rsp_cyc + 1)
          chk(cs_n == exp_cs_after, "R6 cs after response", cs_n, exp_cs_after);
        if (hs_c) begin
          int idx;
          idx = exp_index(hs_cnt);
          chk(cmd_data == m_tx[idx], run_wrap ? "R9 data" : "R3 data", cmd_data, m_tx[idx]);
          chk(cmd_len == f_len(m_cmd[idx]), "R3 len", cmd_len, f_len(m_cmd[idx]));
          chk(cmd_cs == f_cs(m_cmd[idx]), "R3 cs", cmd_cs, f_cs(m_cmd[idx]));
          chk(cs_n == ~f_cs(m_cmd[idx]), "R6 cs_n", cs_n, ~f_cs(m_cmd[idx]));
          chk(cur_ptr == 4'(idx), run_wrap ? "R9 cur_ptr" : "R3 cur_ptr", cur_ptr, idx);
          cur_idx = idx;
          hs_cnt++;
        end
        if (hs_r) begin
          last_rsp_cyc = cyc;
          last_dly = f_dly(m_cmd[cur_idx]);
          rsp_seen = 1;
          stop = (!run_wrap && cur_idx == run_end) || (halt_at != 0 && hs_cnt == halt_at);
          exp_cs_after = (f_hold(m_cmd[cur_idx]) && !(stop && last_dly == 0)) ? ~f_cs(m_cmd[cur_idx]) : 4'hF;
        end
      end
      prev_cv = cmd_valid;
      @(posedge clk); #1;
      halt = 0;
      if (hs_r) rsp_valid = 0;
      if (hs_c) begin
        cmd_ready = 0;
        have = 1;
        wait_n = $urandom % 4;
        if (halt_at != 0 && hs_cnt == halt_at) halt = 1;
      end
      if (have) begin
        if (wait_n == 0) begin
          rsp_valid = 1;
          rsp_data = resp_of(cur_idx);
          exp_rx[cur_idx] = rsp_data;
          have = 0;
        end else wait_n--;
      end else if (!rsp_valid && !hs_c) begin
        cmd_ready = ($urandom % 3) != 0;
      end
    end
  end

  task automatic host_write(input int a, input logic [1:0] f, input logic [16:0] d);
    @(posedge clk); #1;
    host_we = 1; host_addr = 4'(a); host_fld = f; host_wdata = d;
    @(posedge clk); #1;
    host_we = 0;
  endtask

  task automatic host_read(input int a, input logic [1:0] f, output logic [16:0] d);
    @(posedge clk); #1;
    host_addr = 4'(a); host_fld = f;
    @(posedge clk);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic set_slot(input int i, input logic [15:0] tx, input logic [16:0] c);
    m_tx[i] = tx; m_cmd[i] = c;
    host_write(i, 2'd0, {1'b0, tx});
    host_write(i, 2'd2, c);
  endtask

  task automatic load_random;
    for (int i = 0; i < 16; i++)
      set_slot(i, 16'($urandom), {1'($urandom), 4'($urandom_range(1, 15)), 4'($urandom),
                                  8'($urandom % 6)});
  endtask

  task automatic pulse_go(input int s, input int e, input bit w);
    run_start = s; run_end = e; run_wrap = w;
    run_len = ((e - s) & 15) + 1;
    hs_cnt = 0;
    @(posedge clk); #1;
    go = 1; start_ptr = 4'(s); end_ptr = 4'(e); wrap_en = w;
    @(posedge clk); #1;
    go = 0;
    @(negedge clk);
    chk(busy == 1'b1, "R3 busy after go", busy, 1);
    chk(done == 1'b0, "R8 done cleared by go", done, 0);
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic finish_run(input string tag);
    logic [16:0] d;
    wait_idle();
    chk(busy == 1'b0, "R8 busy low", busy, 0);
    chk(done == 1'b1, "R8 done high", done, 1);
    chk(cs_n == 4'hF, "R8 cs released", cs_n, 4'hF);
    chk(hs_cnt == run_len, tag, hs_cnt, run_len);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R8 done sticky", done, 1);
    for (int k = 0; k < run_len; k++) begin
      int idx;
      idx = exp_index(k);
      host_read(idx, 2'd1, d);
      chk(d[15:0] == exp_rx[idx], "R5 rx stored", d, exp_rx[idx]);
    end
  endtask

  initial begin
    logic [16:0] d;
    void'($urandom(32'd20240611));
    rst_n = 0; go = 0; wrap_en = 0; start_ptr = 0; end_ptr = 0;
    host_we = 0; host_fld = 0; host_addr = 0; host_wdata = 0;
    hs_cnt = 0; halt_at = 0; run_start = 0; run_end = 0; run_len = 1; run_wrap = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 busy/done in reset", {busy, done}, 0);
    chk(cs_n == 4'hF, "R1 cs_n in reset", cs_n, 4'hF);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(cmd_valid == 0 && rsp_ready == 0, "R1 streams idle", {cmd_valid, rsp_ready}, 0);
    chk(cur_ptr == 0, "R1 cur_ptr", cur_ptr, 0);

    // R2 host access, all three fields
    host_write(3, 2'd0, 17'h0BEEF);
    host_write(3, 2'd2, 17'h1A5C7);
    host_write(3, 2'd1, 17'h01357);
    host_read(3, 2'd0, d); chk(d == 17'h0BEEF, "R2 tx readback", d, 17'h0BEEF);
    host_read(3, 2'd2, d); chk(d == 17'h1A5C7, "R2 cmd readback", d, 17'h1A5C7);
    host_read(3, 2'd1, d); chk(d == 17'h01357, "R2 rx readback", d, 17'h01357);

    load_random();
    // single slot
    pulse_go(2, 2, 0);
    finish_run("R3 single slot count");
    // long pause with hold select on slot 5
    set_slot(5, 16'hC0DE, {1'b1, 4'b0101, 4'd11, 8'd37});
    pulse_go(5, 6, 0);
    finish_run("R7 long pause run count");
    // wrap through slot 0
    pulse_go(14, 1, 0);
    finish_run("R11 wrapped range count");
    // second go while busy is ignored
    pulse_go(4, 9, 0);
    repeat (6) @(posedge clk);
    #1 go = 1; start_ptr = 4'd0; end_ptr = 4'd15;
    @(posedge clk); #1 go = 0;
    finish_run("R3 go while busy ignored");
    // full queue and random runs
    pulse_go(0, 15, 0);
    finish_run("R3 full queue count");
    for (int r = 0; r < 6; r++) begin
      load_random();
      pulse_go(int'($urandom % 16), int'($urandom % 16), 0);
      finish_run("R3 random run count");
    end
    // endless wrap stopped by halt
    halt_at = 7;
    pulse_go(5, 7, 1);
    wait_idle();
    chk(hs_cnt == 7, "R10 halt count", hs_cnt, 7);
    chk(hs_cnt > run_len, "R9 went past last slot", hs_cnt, run_len);
    chk(done == 1'b0, "R10 done stays low", done, 0);
    chk(busy == 1'b0 && cs_n == 4'hF, "R10 stopped", {busy, cs_n}, 5'h0F);
    halt_at = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule